// File: doc/BRIEF.md
# Command Response Capture FIFO

This block receives a card's reply on the serial command line once the command transmitter has sent the command's end bit. Software picks the reply format with a 2-bit kind field when the command goes out. The block then waits for the reply's start bit. It shifts in the reply one bit per card clock tick and checks the 7-bit CRC where the format carries one. It also watches for a missing reply, using a programmable limit counted in card clock ticks.

The captured bits are presented through a 16-bit read port backed by an eight-entry FIFO. Each halfword becomes readable as soon as its sixteen bits have arrived. Three sticky flags report the outcome of the last command: finished, checksum mismatch, and no reply. All three clear when the next command is issued. The same event empties the FIFO.

Top module: `rsp_capture`

## Requirements
- R1: Kind value 0 (no reply) makes the block report finished one cycle after `cmd_sent`, with an empty FIFO and both error flags low; later line activity stores nothing.
- R2: Kinds 1 and 3 take a 48-bit frame (first bit on the wire is frame bit 47) and store three halfwords a = frame[47:32], b = frame[31:16], c = frame[15:0]. The 32-bit payload ((a<<24)|(b<<8)|(c>>8)) therefore equals frame[39:8], and the checksum byte sits in the low half of c.
- R3: Kind 2 takes a 136-bit frame, drops its first eight bits and stores frame[127:0] as eight halfwords, most significant first. Consecutive pairs form four 32-bit words, with the first halfword of each pair in the high half.
- R4: The checksum is CRC7 with polynomial x^7+x^3+1 and a zero start value, fed most significant bit first. It covers frame[47:8] for kind 1 and frame[127:8] for kind 2, and is compared with frame[7:1]. A mismatch sets `rsp_crc_err` together with `rsp_done`.
- R5: Kind 3 never raises `rsp_crc_err`, whatever the checksum field holds.
- R6: The reply starts at the first 0 sampled on `cmd_line` on a `bit_tick` after `cmd_sent`. Ticks with the line high before that are not stored.
- R7: With limit L, if the line stays high on L+1 consecutive ticks while waiting, the tick that exceeds the limit sets `rsp_timeout` and `rsp_done`, and no data is stored. A start bit on tick L+1 is still accepted.
- R8: The limit resets to all ones (255 at the default width). Asserting `to_we` loads `to_wdata` into the limit.
- R9: A read with an empty FIFO returns 0 and leaves the level unchanged.
- R10: `cmd_sent` empties the FIFO and clears all three flags. An accompanying read or tick has no effect.
- R11: Once `rsp_done` is set, further ticks change neither the flags nor the FIFO until the next `cmd_sent`.
- R12: `fifo_level` counts the stored halfwords. Each read of a non-empty FIFO removes exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Card clock sampling strobe, one system cycle wide |
| cmd_line | input | 1 | Serial command line from the card |
| cmd_sent | input | 1 | Pulse: command end bit sent; starts a new capture |
| rsp_kind | input | 2 | Reply format: 0 none, 1 48-bit checked, 2 136-bit, 3 48-bit unchecked |
| to_we | input | 1 | Load the timeout limit |
| to_wdata | input | TO_W | New timeout limit in card clock ticks |
| rd_en | input | 1 | Pop one halfword |
| rd_data | output | 16 | Head halfword, 0 when empty |
| fifo_level | output | 4 | Number of halfwords held |
| rsp_done | output | 1 | Reply finished, timed out, or none expected |
| rsp_crc_err | output | 1 | Checksum mismatch |
| rsp_timeout | output | 1 | No start bit within the limit |

## Verification
The bench builds the block with the default limit width of 8. This makes the reset limit of 255 observable: the run waits through all 256 high ticks and sees the timeout on the last one. It then lowers the limit to 10 and 20, so that both edges of the waiting window can be hit: a start bit exactly on the last allowed tick, and a timeout one tick later. These short limits also keep random start-bit gaps close to that edge. Random frames of all three reply kinds, some with a single corrupted bit, are sent with random idle cycles between ticks.

// File: rtl/rsp_capture.sv
module rsp_capture #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            cmd_line,
  input  logic            cmd_sent,
  input  logic [1:0]      rsp_kind,
  input  logic            to_we,
  input  logic [TO_W-1:0] to_wdata,
  input  logic            rd_en,
  output logic [15:0]     rd_data,
  output logic [3:0]      fifo_level,
  output logic            rsp_done,
  output logic            rsp_crc_err,
  output logic            rsp_timeout
);

  localparam int DEPTH = 8;
  localparam int PW    = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;

  st_t             st;
  logic [1:0]      kind;
  logic [7:0]      idx;
  logic [TO_W-1:0] to_limit, wait_cnt;
  logic [14:0]     sr;
  logic [6:0]      crc, rx_crc;
  logic [15:0]     mem [DEPTH];
  logic [PW:0]     wp, rp;

  logic [7:0] flen, skip, cur_idx;
  logic       take, last, push, pop, empty, in_crc, in_rx, fb;

  assign flen    = (kind == 2'd2) ? 8'd136 : 8'd48;
  assign skip    = (kind == 2'd2) ? 8'd8 : 8'd0;
  assign cur_idx = (st == S_WAIT) ? 8'd0 : idx;
  assign take    = !cmd_sent && bit_tick &&
                   ((st == S_SHIFT) || (st == S_WAIT && !cmd_line));
  assign last    = take && (cur_idx == flen - 8'd1);
  assign push    = take && (cur_idx >= skip) &&
                   (cur_idx[3:0] == ((kind == 2'd2) ? 4'd7 : 4'd15));
  assign empty   = (wp == rp);
  assign pop     = !cmd_sent && rd_en && !empty;
  assign in_crc  = (cur_idx >= skip) && (cur_idx <= flen - 8'd9);
  assign in_rx   = (cur_idx >= flen - 8'd8) && (cur_idx <= flen - 8'd2);
  assign fb      = crc[6] ^ cmd_line;

  assign rd_data    = empty ? 16'h0000 : mem[rp[PW-1:0]];
  assign fifo_level = 4'(wp - rp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kind        <= 2'd0;
      idx         <= 8'd0;
      to_limit    <= '1;
      wait_cnt    <= '0;
      sr          <= '0;
      crc         <= '0;
      rx_crc      <= '0;
      wp          <= '0;
      rp          <= '0;
      rsp_done    <= 1'b0;
      rsp_crc_err <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      if (to_we) to_limit <= to_wdata;
      if (cmd_sent) begin
        kind        <= rsp_kind;
        st          <= (rsp_kind == 2'd0) ? S_IDLE : S_WAIT;
        rsp_done    <= (rsp_kind == 2'd0);
        rsp_crc_err <= 1'b0;
        rsp_timeout <= 1'b0;
        wait_cnt    <= '0;
        idx         <= 8'd0;
        crc         <= '0;
        rx_crc      <= '0;
        wp          <= '0;
        rp          <= '0;
      end else begin
        if (pop) rp <= rp + 1'b1;
        if (st == S_WAIT && bit_tick && cmd_line) begin
          if (wait_cnt == to_limit) begin
            st          <= S_IDLE;
            rsp_done    <= 1'b1;
            rsp_timeout <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        if (take) begin
          sr  <= {sr[13:0], cmd_line};
          idx <= cur_idx + 8'd1;
          if (st == S_WAIT) st <= S_SHIFT;
          if (in_crc) crc <= {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
          if (in_rx)  rx_crc <= {rx_crc[5:0], cmd_line};
          if (push) begin
            mem[wp[PW-1:0]] <= {sr, cmd_line};
            wp <= wp + 1'b1;
          end
          if (last) begin
            st          <= S_IDLE;
            rsp_done    <= 1'b1;
            rsp_crc_err <= (kind != 2'd3) && (crc != rx_crc);
          end
        end
      end
    end
  end

  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= 4'(DEPTH));

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |=> (fifo_level == 4'd0) && !rsp_crc_err && !rsp_timeout);

  assert_err_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_crc_err |-> rsp_done);

  assert_unchecked_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd3) |-> !rsp_crc_err);

  assert_timeout_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> (fifo_level == 4'd0) && rsp_done && !rsp_crc_err);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == 4'd0 && rd_en && !bit_tick) |=> (fifo_level == 4'd0));

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !cmd_sent) |=> rsp_done && $stable(rsp_crc_err) && $stable(rsp_timeout));

  assert_frozen_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !cmd_sent && !rd_en) |=> $stable(fifo_level));

endmodule

// File: tb/rsp_capture_tb_top.sv
`timescale 1ns/1ps
module rsp_capture_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, cmd_line = 1'b1, cmd_sent = 1'b0, to_we = 1'b0, rd_en = 1'b0;
  logic [1:0] rsp_kind = 2'd0;
  logic [7:0] to_wdata = 8'd0;
  logic [15:0] rd_data;
  logic [3:0] fifo_level;
  logic rsp_done, rsp_crc_err, rsp_timeout;
  int checks = 0, errors = 0, idle_max = 0;

  always #2.5 clk = ~clk;

  rsp_capture #(.TO_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cmd_line(cmd_line),
    .cmd_sent(cmd_sent), .rsp_kind(rsp_kind), .to_we(to_we), .to_wdata(to_wdata),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level), .rsp_done(rsp_done),
    .rsp_crc_err(rsp_crc_err), .rsp_timeout(rsp_timeout));

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] f, input int hi, input int lo);
    logic [6:0] c = 7'd0;
    for (int i = hi; i >= lo; i--) begin
      logic b = c[6] ^ f[i];
      c = {c[5:0], 1'b0} ^ (b ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [135:0] make_frame(input logic [1:0] k);
    logic [135:0] f = '0;
    if (k == 2'd2) begin
      f[135:134] = 2'b00;
      f[133:128] = 6'h3F;
      f[127:8] = {$urandom, $urandom, $urandom, $urandom};
      f[7:1] = crc7(f, 127, 8);
    end else begin
      f[47:46] = 2'b00;
      f[45:40] = 6'($urandom);
      f[39:8] = $urandom;
      f[7:1] = crc7(f, 47, 8);
    end
    f[0] = 1'b1;
    return f;
  endfunction

  function automatic logic [15:0] exp_hw(input logic [135:0] f, input logic [1:0] k, input int n);
    if (k == 2'd2) return f[127 - 16*n -: 16];
    return f[47 - 16*n -: 16];
  endfunction

  task automatic send_cmd(input logic [1:0] k);
    cmd_sent = 1'b1; rsp_kind = k;
    @(negedge clk);
    cmd_sent = 1'b0;
  endtask

  task automatic tick(input logic b);
    bit_tick = 1'b1; cmd_line = b;
    @(negedge clk);
    bit_tick = 1'b0; cmd_line = 1'b1;
    repeat ($urandom_range(idle_max, 0)) @(negedge clk);
  endtask

  task automatic pop(output logic [15:0] v);
    v = rd_data; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_limit(input logic [7:0] l);
    to_we = 1'b1; to_wdata = l;
    @(negedge clk);
    to_we = 1'b0;
  endtask

  task automatic run_frame(input logic [1:0] k, input logic [135:0] f, input int gap, input logic bad);
    int len = (k == 2'd2) ? 136 : 48;
    int nhw = (k == 2'd2) ? 8 : 3;
    logic [15:0] v;
    logic [15:0] hw [8];
    send_cmd(k);
    chk(fifo_level == 0 && !rsp_done, "R10", "flush on new command", {fifo_level, 3'b0, rsp_done}, 0);
    for (int i = 0; i < gap; i++) tick(1'b1);
    chk(fifo_level == 0 && !rsp_done, "R6", "high ticks before start", {fifo_level, 3'b0, rsp_done}, 0);
    for (int i = len - 1; i >= 0; i--) tick(f[i]);
    chk(rsp_done && !rsp_timeout, "R6", "done after frame", {rsp_done, rsp_timeout}, 2'b10);
    chk(rsp_crc_err == (bad && k != 2'd3), (k == 2'd3) ? "R5" : "R4", "checksum flag",
        rsp_crc_err, bad && k != 2'd3);
    chk(fifo_level == 4'(nhw), "R12", "level after frame", fifo_level, nhw);
    for (int n = 0; n < nhw; n++) begin
      pop(v); hw[n] = v;
      chk(v == exp_hw(f, k, n), (k == 2'd2) ? "R3" : "R2", "halfword", v, exp_hw(f, k, n));
      chk(fifo_level == 4'(nhw - n - 1), "R12", "level after read", fifo_level, nhw - n - 1);
    end
    if (k != 2'd2)
      chk(((32'(hw[0]) << 24) | (32'(hw[1]) << 8) | (32'(hw[2]) >> 8)) == f[39:8], "R2", "payload",
          (32'(hw[0]) << 24) | (32'(hw[1]) << 8) | (32'(hw[2]) >> 8), f[39:8]);
    else
      chk({hw[6], hw[7]} == f[31:0], "R3", "last word", {hw[6], hw[7]}, f[31:0]);
    pop(v);
    chk(v == 16'h0 && fifo_level == 0, "R9", "empty read", {v, fifo_level}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [135:0] f;
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_level == 0 && !rsp_done && !rsp_crc_err && !rsp_timeout && rd_data == 0, "R9",
        "reset state", {rd_data, fifo_level, rsp_done, rsp_crc_err, rsp_timeout}, 0);

    // R8: reset limit 255 -> 256th high tick times out
    send_cmd(2'd1);
    for (int i = 0; i < 255; i++) tick(1'b1);
    chk(!rsp_done, "R8", "no timeout at 255 ticks", rsp_done, 0);
    tick(1'b1);
    chk(rsp_done && rsp_timeout && fifo_level == 0, "R8", "timeout at 256", {rsp_done, rsp_timeout}, 2'b11);

    // R7: limit 10, start on tick 11 accepted; tick 11 high times out
    set_limit(8'd10);
    f = make_frame(2'd1);
    run_frame(2'd1, f, 10, 1'b0);
    send_cmd(2'd2);
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk(!rsp_done, "R7", "waiting within limit", rsp_done, 0);
    tick(1'b1);
    chk(rsp_done && rsp_timeout && !rsp_crc_err, "R7", "timeout flags", {rsp_done, rsp_timeout, rsp_crc_err}, 3'b110);
    tick(1'b0); tick(1'b0);
    chk(fifo_level == 0 && rsp_timeout, "R11", "ticks after timeout", {fifo_level, rsp_timeout}, 1);

    // R1: no reply
    send_cmd(2'd0);
    chk(rsp_done && !rsp_timeout && !rsp_crc_err && fifo_level == 0, "R1", "kind none",
        {rsp_done, rsp_timeout, rsp_crc_err, fifo_level}, 7'b1000000);
    for (int i = 0; i < 20; i++) tick(1'b0);
    chk(fifo_level == 0 && rsp_done, "R1", "line ignored", {fifo_level, rsp_done}, 1);

    // R12: halfword available mid-reception (kind 2)
    f = make_frame(2'd2);
    send_cmd(2'd2);
    for (int i = 135; i >= 113; i--) tick(f[i]);
    chk(fifo_level == 0, "R12", "23 bits stored none", fifo_level, 0);
    tick(f[112]);
    chk(fifo_level == 1 && rd_data == f[127:112], "R12", "24 bits first halfword", rd_data, f[127:112]);

    // R10: cmd_sent with simultaneous read and tick
    cmd_sent = 1'b1; rsp_kind = 2'd1; rd_en = 1'b1; bit_tick = 1'b1; cmd_line = 1'b0;
    @(negedge clk);
    cmd_sent = 1'b0; rd_en = 1'b0; bit_tick = 1'b0; cmd_line = 1'b1;
    chk(fifo_level == 0 && !rsp_done && !rsp_crc_err, "R10", "flush with concurrent inputs", fifo_level, 0);

    // R11: ticks after a completed frame
    f = make_frame(2'd1);
    f[20] = ~f[20];
    send_cmd(2'd1);
    for (int i = 47; i >= 0; i--) tick(f[i]);
    for (int i = 0; i < 30; i++) tick(1'($urandom));
    chk(rsp_done && rsp_crc_err && fifo_level == 3, "R11", "frozen after done",
        {rsp_done, rsp_crc_err, fifo_level}, 6'b110011);
    pop(v);
    chk(v == f[47:32], "R2", "first halfword of bad frame", v, f[47:32]);

    // random frames
    set_limit(8'd20);
    idle_max = 2;
    for (int it = 0; it < 40; it++) begin
      logic [1:0] k = 2'($urandom_range(3, 1));
      logic bad = ($urandom_range(3, 0) == 0);
      int len = (k == 2'd2) ? 136 : 48;
      f = make_frame(k);
      if (bad) begin
        int p = (k == 2'd2) ? $urandom_range(127, 1) : $urandom_range(46, 1);
        f[p] = ~f[p];
      end
      if (len == 0) f = '0;
      run_frame(k, f, $urandom_range(20, 0), bad);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule